// File: doc/BRIEF.md
# Guarded Multiply-Accumulate Unit

This block is a multiply-accumulate datapath for signal-processing kernels such as filters and correlators. On every clock it can take one 16-bit by 16-bit product and add it into a 40-bit accumulator. The accumulator is 8 bits wider than a product, so long runs of accumulation do not overflow.

Each operand is taken from a 32-bit source word. A select input picks the low or the high half of both source words, and a second input sets whether the halves are two's-complement or unsigned numbers. The add into the accumulator either wraps modulo 2^40 or, when saturation is enabled, clamps to the most positive or most negative 40-bit value. A clamp sets a sticky flag.

The accumulator can be cleared or loaded from a 40-bit input. It is always visible as a pair of 32-bit words, as it would be held in an even/odd register pair: a low word, and a high word that holds the top 8 bits sign-extended. Instruction decode and register files are outside the block; the operands arrive on ports.

Top module: `mac_guard40`

## Requirements
- R1: While `rst_n` is low, the accumulator and `sat_flag` are reset to zero, so `acc_even`, `acc_odd` and `sat_flag` all read 0 after reset.
- R2: With `mac_en` high, one product is added into the accumulator at every rising clock edge. Back-to-back cycles each add their own product, and each result is visible at the outputs after that edge.
- R3: With `hi_sel` = 0, the multiplier uses bits [15:0] of `src_a` and `src_b`. With `hi_sel` = 1, it uses bits [31:16] of both.
- R4: With `is_signed` = 1, both selected halves are treated as two's-complement numbers. With `is_signed` = 0, both are treated as unsigned, so 0xFFFF x 0xFFFF adds +0xFFFE0001.
- R5: With `sat_en` = 0, the addition wraps modulo 2^40 and `sat_flag` does not change.
- R6: With `sat_en` = 1, a sum above 0x7F_FFFF_FFFF becomes 0x7F_FFFF_FFFF, and a sum below -2^39 becomes 0x80_0000_0000.
- R7: `sat_flag` goes to 1 on any clamped addition and stays at 1 until a clear.
- R8: `clr` takes priority over both `ld_en` and `mac_en`. It sets the accumulator to 0 and `sat_flag` to 0.
- R9: `ld_en` with `clr` low replaces the accumulator with `ld_val`, taking priority over `mac_en`. A load leaves `sat_flag` unchanged.
- R10: `acc_even` shows accumulator bits [31:0]. `acc_odd` shows bits [39:32] in its low 8 bits, with bit 39 copied into bits [31:8].
- R11: When `clr`, `ld_en` and `mac_en` are all low, the accumulator and `sat_flag` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_a | input | 32 | First source word |
| src_b | input | 32 | Second source word |
| hi_sel | input | 1 | 1 selects the high halves of both source words, 0 the low halves |
| is_signed | input | 1 | 1 treats both operands as two's complement, 0 as unsigned |
| sat_en | input | 1 | Enables saturating addition |
| mac_en | input | 1 | Adds the product into the accumulator this cycle |
| clr | input | 1 | Clears the accumulator and the flag (highest priority) |
| ld_en | input | 1 | Loads `ld_val` into the accumulator |
| ld_val | input | 40 | Load value |
| acc_even | output | 32 | Accumulator bits [31:0] |
| acc_odd | output | 32 | Accumulator bits [39:32], sign-extended |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with its default parameters: 16-bit operands and a 40-bit accumulator, which gives 8 guard bits.

A sweep runs every pair drawn from eight source words under all four combinations of half select and signedness. It accumulates without a break and checks the result after every cycle against a 64-bit arithmetic model. The source words are chosen so that both halves hit the sign boundaries.

The 40-bit limits cannot be reached by accumulation in a short run, so the bench loads values next to those limits. From there a single product pushes the sum past either limit, which brings wrap, clamp, the sticky flag and the priority of the control inputs within a few cycles.

// File: rtl/mac40_pkg.sv
// Shared types for the guarded multiply-accumulate unit.
// Assumes: nothing beyond standard SystemVerilog.
package mac40_pkg;

    // Accumulator update chosen in a cycle, after priority is applied.
    typedef enum logic [1:0] {
        ACC_HOLD  = 2'd0,
        ACC_CLEAR = 2'd1,
        ACC_LOAD  = 2'd2,
        ACC_MAC   = 2'd3
    } acc_op_e;

endpackage

// File: rtl/mac40_opsel.sv
// Operand selector: takes the low or high half of a source word and widens
// it by one bit, as a sign bit or as a zero, so that both signed and
// unsigned values can be held as signed numbers.
// Assumes: the source word is exactly two operand halves wide.
module mac40_opsel #(
    parameter int OP_W = 16
) (
    input  logic [2*OP_W-1:0]    src,
    input  logic                 hi_sel,
    input  logic                 is_signed,
    output logic signed [OP_W:0] opnd
);
    logic [OP_W-1:0] half;

    // Pick the half, then add a sign bit or a zero bit in front of it.
    always_comb begin
        half = hi_sel ? src[2*OP_W-1:OP_W] : src[OP_W-1:0];
        opnd = {is_signed & half[OP_W-1], half};
    end
endmodule

// File: rtl/mac40_mult.sv
// Multiplier: takes two widened operands and returns their product
// sign-extended to the accumulator width.
// Assumes: ACC_W >= 2*OP_W+2, so the product always fits in the accumulator.
module mac40_mult #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic signed [OP_W:0]    opnd_a,
    input  logic signed [OP_W:0]    opnd_b,
    output logic        [ACC_W-1:0] prod_ext
);
    localparam int PROD_W = 2*OP_W + 2;

    logic signed [PROD_W-1:0] prod;

    // Full-width signed product, then sign extension to the accumulator.
    always_comb begin
        prod     = PROD_W'(opnd_a) * PROD_W'(opnd_b);
        prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end
endmodule

// File: rtl/mac40_satadd.sv
// Accumulator adder: adds the addend into the accumulator with one extra
// bit so that overflow can be seen. On overflow it wraps, or clamps to the
// nearer limit when saturation is enabled.
// Assumes: both inputs are two's-complement values of width ACC_W.
module mac40_satadd #(
    parameter int ACC_W = 40
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] addend,
    input  logic             sat_en,
    output logic [ACC_W-1:0] result,
    output logic             sat_hit
);
    localparam logic [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0] sum_x;
    logic           ovf;

    // Add with one extra bit, detect overflow, and choose wrap or clamp.
    always_comb begin
        sum_x   = {acc_in[ACC_W-1], acc_in} + {addend[ACC_W-1], addend};
        ovf     = sum_x[ACC_W] ^ sum_x[ACC_W-1];
        sat_hit = sat_en & ovf;
        if (sat_hit)
            result = sum_x[ACC_W] ? NEG_LIM : POS_LIM;
        else
            result = sum_x[ACC_W-1:0];
    end
endmodule

// File: rtl/mac_guard40.sv
// Guarded multiply-accumulate unit: one half-word product per clock is
// added into an accumulator that is wider than a product, with optional
// saturation, clear, load, and a readout split across an even/odd word pair.
// Assumes: ACC_W > 2*OP_W, ACC_W - 2*OP_W < 2*OP_W, and ACC_W >= 2*OP_W+2.
module mac_guard40 #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*OP_W-1:0]    src_a,
    input  logic [2*OP_W-1:0]    src_b,
    input  logic                 hi_sel,
    input  logic                 is_signed,
    input  logic                 sat_en,
    input  logic                 mac_en,
    input  logic                 clr,
    input  logic                 ld_en,
    input  logic [ACC_W-1:0]     ld_val,
    output logic [2*OP_W-1:0]    acc_even,
    output logic [2*OP_W-1:0]    acc_odd,
    output logic                 sat_flag
);
    import mac40_pkg::*;

    localparam int WORD_W  = 2*OP_W;
    localparam int GUARD_W = ACC_W - WORD_W;
    localparam int N_SRC   = 2;

    logic [WORD_W-1:0]    src_arr  [N_SRC];
    logic signed [OP_W:0] opnd_arr [N_SRC];
    logic [ACC_W-1:0]     prod_ext;
    logic [ACC_W-1:0]     sum_res;
    logic                 sat_hit;
    logic [ACC_W-1:0]     acc_q;
    logic                 flag_q;
    acc_op_e              acc_op;

    // Gather the source words into an array for the selector loop.
    always_comb begin
        src_arr[0] = src_a;
        src_arr[1] = src_b;
    end

    // One operand selector per source word.
    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_sel
        mac40_opsel #(.OP_W(OP_W)) sel_i (
            .src       (src_arr[gi]),
            .hi_sel    (hi_sel),
            .is_signed (is_signed),
            .opnd      (opnd_arr[gi])
        );
    end

    mac40_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) mult_i (
        .opnd_a   (opnd_arr[0]),
        .opnd_b   (opnd_arr[1]),
        .prod_ext (prod_ext)
    );

    mac40_satadd #(.ACC_W(ACC_W)) add_i (
        .acc_in  (acc_q),
        .addend  (prod_ext),
        .sat_en  (sat_en),
        .result  (sum_res),
        .sat_hit (sat_hit)
    );

    // Priority decode: clear, then load, then accumulate, otherwise hold.
    always_comb begin
        if (clr)         acc_op = ACC_CLEAR;
        else if (ld_en)  acc_op = ACC_LOAD;
        else if (mac_en) acc_op = ACC_MAC;
        else             acc_op = ACC_HOLD;
    end

    // Accumulator and sticky flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            unique case (acc_op)
                ACC_CLEAR: begin
                    acc_q  <= '0;
                    flag_q <= 1'b0;
                end
                ACC_LOAD:  acc_q <= ld_val;
                ACC_MAC: begin
                    acc_q  <= sum_res;
                    flag_q <= flag_q | sat_hit;
                end
                default:   acc_q <= acc_q;
            endcase
        end
    end

    // Split readout: low word as stored, guard bits sign-extended.
    always_comb begin
        acc_even = acc_q[WORD_W-1:0];
        acc_odd  = {{(WORD_W-GUARD_W){acc_q[ACC_W-1]}}, acc_q[ACC_W-1:WORD_W]};
        sat_flag = flag_q;
    end
endmodule

// File: rtl/mac_guard40_chk.sv
// Assertion checker for the guarded multiply-accumulate unit; it observes
// the ports only.
// Assumes: it is bound to every instance of mac_guard40.
module mac_guard40_chk #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mac_en,
    input logic                 clr,
    input logic                 ld_en,
    input logic [ACC_W-1:0]     ld_val,
    input logic [2*OP_W-1:0]    acc_even,
    input logic [2*OP_W-1:0]    acc_odd,
    input logic                 sat_flag
);
    localparam int WORD_W  = 2*OP_W;
    localparam int GUARD_W = ACC_W - WORD_W;

    logic [ACC_W-1:0] acc_view;
    assign acc_view = {acc_odd[GUARD_W-1:0], acc_even};

    // R1: reset leaves a zero accumulator and a cleared flag.
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (acc_even == '0 && acc_odd == '0 && !sat_flag));

    // R8: clear wins over everything and zeroes the flag.
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_even == '0 && acc_odd == '0 && !sat_flag));

    // R9: load replaces the accumulator and leaves the flag alone.
    a_r9_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && !clr) |=> (acc_view == $past(ld_val) && sat_flag == $past(sat_flag)));

    // R11: idle cycles hold the state.
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !ld_en && !mac_en) |=> ($stable(acc_even) && $stable(acc_odd) && $stable(sat_flag)));

    // R7: the flag stays set until a clear.
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !clr) |=> sat_flag);

    // R6: a new flag comes with an accumulator at one of the two limits.
    a_r6_clamp_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_flag) |-> (acc_view == {1'b0, {(ACC_W-1){1'b1}}} ||
                             acc_view == {1'b1, {(ACC_W-1){1'b0}}}));

    // R10: the odd word is a sign extension of the guard bits.
    a_r10_odd_extend: assert property (@(posedge clk) disable iff (!rst_n)
        acc_odd[WORD_W-1:GUARD_W] == {(WORD_W-GUARD_W){acc_odd[GUARD_W-1]}});
endmodule

bind mac_guard40 mac_guard40_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mac_en   (mac_en),
    .clr      (clr),
    .ld_en    (ld_en),
    .ld_val   (ld_val),
    .acc_even (acc_even),
    .acc_odd  (acc_odd),
    .sat_flag (sat_flag)
);

// File: tb/mac_guard40_tb_top.sv
// Self-checking bench for mac_guard40: a swept accumulation against a
// 64-bit arithmetic model, plus directed cases at the 40-bit limits.
module mac_guard40_tb_top;
    localparam int OP_W  = 16;
    localparam int ACC_W = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic        hi_sel = 0, is_signed = 0, sat_en = 0, mac_en = 0, clr = 0, ld_en = 0;
    logic [39:0] ld_val = '0;
    logic [31:0] acc_even, acc_odd;
    logic        sat_flag;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 0;

    longint exp_acc  = 0;
    bit     exp_flag = 0;

    localparam longint MAXV = (64'sd1 <<< 39) - 1;
    localparam longint MINV = -(64'sd1 <<< 39);

    always #2 clk = ~clk;

    mac_guard40 #(.OP_W(OP_W), .ACC_W(ACC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .hi_sel(hi_sel), .is_signed(is_signed), .sat_en(sat_en),
        .mac_en(mac_en), .clr(clr), .ld_en(ld_en), .ld_val(ld_val),
        .acc_even(acc_even), .acc_odd(acc_odd), .sat_flag(sat_flag)
    );

    function automatic longint opnd(input logic [31:0] s, input bit hi, input bit sg);
        logic [15:0] h;
        h = hi ? s[31:16] : s[15:0];
        if (sg) return {{48{h[15]}}, h};
        return {48'd0, h};
    endfunction

    function automatic longint wrap40(input longint v);
        longint w;
        w = v & ((64'sd1 <<< 40) - 1);
        if (w[39]) w = w - (64'sd1 <<< 40);
        return w;
    endfunction

    // Model one accumulate using the current inputs.
    task automatic model_mac();
        longint sum;
        sum = exp_acc + opnd(src_a, hi_sel, is_signed) * opnd(src_b, hi_sel, is_signed);
        if (sat_en && sum > MAXV) begin exp_acc = MAXV; exp_flag = 1; end
        else if (sat_en && sum < MINV) begin exp_acc = MINV; exp_flag = 1; end
        else exp_acc = wrap40(sum);
    endtask

    task automatic check(input string req);
        logic [31:0] e_even, e_odd;
        e_even = exp_acc[31:0];
        e_odd  = {{24{exp_acc[39]}}, exp_acc[39:32]};
        n_tests++;
        if (acc_even !== e_even || acc_odd !== e_odd || sat_flag !== exp_flag) begin
            n_fail++;
            $display("FAIL %s: got even=%h odd=%h flag=%b, expected even=%h odd=%h flag=%b",
                     req, acc_even, acc_odd, sat_flag, e_even, e_odd, exp_flag);
        end
    endtask

    // Clock once and settle away from the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_ctl();
        mac_en = 0; clr = 0; ld_en = 0;
    endtask

    task automatic do_load(input logic [39:0] v);
        idle_ctl(); ld_en = 1; ld_val = v;
        tick();
        exp_acc = wrap40(longint'({24'd0, v}));
        idle_ctl();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] vals [8];
        vals[0] = 32'h0000_0000; vals[1] = 32'hFFFF_FFFF;
        vals[2] = 32'h8000_7FFF; vals[3] = 32'h7FFF_8000;
        vals[4] = 32'h0001_FFFE; vals[5] = 32'h1234_ABCD;
        vals[6] = 32'hC3A5_0003; vals[7] = 32'h0002_0001;

        // R1: reset state
        mac_en = 1; src_a = 32'hFFFF_FFFF; src_b = 32'hFFFF_FFFF;
        tick(); tick();
        check("R1 reset");
        idle_ctl();
        rst_n = 1;
        tick();
        check("R11 idle after reset");

        // R2 R3 R4: continuous sweep, one product per clock
        for (int sg = 0; sg < 2; sg++)
            for (int hi = 0; hi < 2; hi++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++) begin
                        src_a = vals[i]; src_b = vals[j];
                        hi_sel = hi[0]; is_signed = sg[0]; sat_en = 0; mac_en = 1;
                        model_mac();
                        tick();
                        check("R2 R3 R4 sweep");
                    end
        idle_ctl();

        // R4: unsigned maximum product
        do_load(40'h0);
        src_a = 32'h0000_FFFF; src_b = 32'h0000_FFFF; hi_sel = 0; is_signed = 0; sat_en = 0;
        mac_en = 1; tick(); idle_ctl();
        exp_acc = 64'h0000_0000_FFFE_0001;
        check("R4 unsigned max");

        // R5: wrap without saturation
        do_load(40'h7F_FFFF_0000);
        src_a = 32'h7FFF_0000; src_b = 32'h7FFF_0000; hi_sel = 1; is_signed = 1; sat_en = 0;
        model_mac(); mac_en = 1; tick(); idle_ctl();
        check("R5 wrap");

        // R6 R7: positive clamp
        do_load(40'h7F_FFFF_0000);
        sat_en = 1;
        model_mac(); mac_en = 1; tick(); idle_ctl();
        check("R6 R7 positive clamp");

        // R11: idle hold keeps value and flag
        tick(); tick();
        check("R11 hold");

        // R9 R7: load keeps the flag set
        do_load(40'h80_0000_0100);
        check("R9 load keeps flag");

        // R6: negative clamp, flag stays
        src_a = 32'h0000_8000; src_b = 32'h0000_7FFF; hi_sel = 0; is_signed = 1; sat_en = 1;
        model_mac(); mac_en = 1; tick(); idle_ctl();
        check("R6 negative clamp");

        // R7: later non-saturating mac keeps the flag
        src_a = 32'h0000_0001; src_b = 32'h0000_0001; is_signed = 1;
        model_mac(); mac_en = 1; tick(); idle_ctl();
        check("R7 sticky");

        // R8: clear wins over load and mac
        clr = 1; ld_en = 1; ld_val = 40'h12_3456_789A; mac_en = 1;
        tick(); idle_ctl();
        exp_acc = 0; exp_flag = 0;
        check("R8 clear priority");

        // R9: load wins over mac
        ld_en = 1; ld_val = 40'h05_0000_0001; mac_en = 1;
        src_a = 32'h0000_7FFF; src_b = 32'h0000_7FFF;
        tick(); idle_ctl();
        exp_acc = 64'h05_0000_0001;
        check("R9 load priority");

        // R10: readout with a negative guard field
        do_load(40'h85_1234_5678);
        check("R10 negative readout");
        n_tests++;
        if (acc_odd !== 32'hFFFF_FF85) begin
            n_fail++;
            $display("FAIL R10: got odd=%h, expected odd=ffffff85", acc_odd);
        end

        // R10: readout with a positive guard field
        do_load(40'h7F_89AB_CDEF);
        check("R10 positive readout");

        // R5: negative wrap without saturation leaves the flag clear
        do_load(40'h80_0000_0000);
        src_a = 32'h0000_FFFF; src_b = 32'h0000_0001; hi_sel = 0; is_signed = 1; sat_en = 0;
        model_mac(); mac_en = 1; tick(); idle_ctl();
        check("R5 negative wrap");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule